// File: doc/BRIEF.md
# ARP Receive Field Parser

This block sits behind an Ethernet receive path and turns an incoming ARP packet into one parallel record. The Ethernet header (destination MAC, source MAC, EtherType) arrives as a word on its own valid/ready handshake. The ARP body follows on a byte-wide AXI4-Stream with tdata, tvalid, tready, tlast and tuser. The block captures the header words. It steers each payload byte by position into a field register, with every multi-byte field most significant byte first. It checks the fixed constant fields and the frame length. It then presents the whole record on one valid/ready output.

Frames that end too early, carry wrong constants or are flagged bad by the sender are dropped. Each drop is reported by a one-cycle error pulse, and no output record is produced for it. Bytes past the 28-byte body are taken and thrown away, and the parsed record is still emitted. While a parsed record waits at the output, both input handshakes are held off. This gives simple back-pressure with no buffering.

Top module: `arp_frame_unpacker`

## Requirements
- R1: `hdr_ready` is high only when the block is idle with no record pending. When `hdr_valid` and `hdr_ready` are both high at a clock edge, the three header words are captured and later appear unchanged on `out_dst_mac`, `out_src_mac` and `out_ethtype`. Header activity during payload reception does not alter them.
- R2: `pl_tready` is high only between header acceptance and the beat carrying `pl_tlast`. Byte index k counts accepted beats from 0. The indices map to fields as follows, each field most significant byte first: hardware type 0–1, protocol type 2–3, hardware length 4, protocol length 5, operation 6–7, sender MAC 8–13, sender IP 14–17, target MAC 18–23, target IP 24–27.
- R3: A frame meets all of these conditions: its last beat has index 27 or higher, its constants are good, and `pl_tuser` is low on that beat. For such a frame, `out_valid` rises in the cycle after the last beat. It then stays high, with all output fields stable, until a cycle with `out_ready` high.
- R4: Bytes at index 28 and above are accepted and change no output field. The record is still emitted after `pl_tlast`.
- R5: A frame whose `pl_tlast` beat has an index below 27 raises `err_short` for exactly one cycle, in the cycle after that beat, and produces no output record.
- R6: A full-length frame is treated as malformed when any of these holds: hardware type is not `EXP_HTYPE` (default 0x0001), protocol type is not `EXP_PTYPE` (default 0x0800), hardware length is not `EXP_HLEN` (default 6), or protocol length is not `EXP_PLEN` (default 4). A malformed frame raises `err_hdr` for one cycle and produces no output record.
- R7: `pl_tuser` high on the `pl_tlast` beat raises `err_bad` for one cycle and drops the frame. This takes precedence over the short-frame and header checks.
- R8: While `out_valid` is high, `pl_tready` and `hdr_ready` are both low.
- R9: `busy` is high from the cycle after header acceptance. It goes low in the cycle after the output handshake, or in the cycle after the dropping beat.
- R10: `rst_n` low asynchronously forces `out_valid`, `busy`, `pl_tready` and all error flags low and `hdr_ready` high, including in the middle of a frame.
- R11: At most one of `err_short`, `err_hdr` and `err_bad` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Ethernet header word valid |
| hdr_ready | output | 1 | Block can take a header |
| hdr_dst_mac | input | 48 | Destination MAC of the frame |
| hdr_src_mac | input | 48 | Source MAC of the frame |
| hdr_ethtype | input | 16 | EtherType of the frame (0x0806 for ARP) |
| pl_tdata | input | 8 | Payload byte |
| pl_tvalid | input | 1 | Payload byte valid |
| pl_tready | output | 1 | Payload byte accepted |
| pl_tlast | input | 1 | Last payload byte of the frame |
| pl_tuser | input | 1 | Frame marked bad, sampled with pl_tlast |
| out_valid | output | 1 | Parsed record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_dst_mac | output | 48 | Captured destination MAC |
| out_src_mac | output | 48 | Captured source MAC |
| out_ethtype | output | 16 | Captured EtherType |
| out_htype | output | 16 | Hardware type |
| out_ptype | output | 16 | Protocol type |
| out_hlen | output | 8 | Hardware address length |
| out_plen | output | 8 | Protocol address length |
| out_oper | output | 16 | Operation code |
| out_sha | output | 48 | Sender hardware address |
| out_spa | output | 32 | Sender protocol address |
| out_tha | output | 48 | Target hardware address |
| out_tpa | output | 32 | Target protocol address |
| busy | output | 1 | Frame in progress or record pending |
| err_short | output | 1 | One-cycle pulse: frame ended early |
| err_hdr | output | 1 | One-cycle pulse: constant field mismatch |
| err_bad | output | 1 | One-cycle pulse: frame flagged bad by sender |

## Verification
The bench builds the block with its default expected constants (hardware type 1, protocol type 0x0800, lengths 6 and 4) and the 48-bit MAC / 32-bit IP layout, which fixes the body at 28 bytes. With that layout, frames of 1, 5, 27, 28, 30, 32 and 60 bytes reach the early-end boundary at index 27, the exact fit, and the saturated byte counter with filler bytes that would overwrite fields if the counter wrapped. Each of the four constant fields is corrupted in turn. Sender-bad frames are also combined with short and malformed frames to exercise the error precedence.

// File: rtl/arp_unpack_pkg.sv
package arp_unpack_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int MAC_W     = 48;
    localparam int IP_W      = 32;
    localparam int ETYPE_W   = 16;
    localparam int MAC_BYTES = MAC_W / BYTE_W;
    localparam int IP_BYTES  = IP_W / BYTE_W;

    // byte offsets inside the ARP body; the order is the wire order
    localparam int OFS_HTYPE = 0;
    localparam int OFS_PTYPE = OFS_HTYPE + 2;
    localparam int OFS_HLEN  = OFS_PTYPE + 2;
    localparam int OFS_PLEN  = OFS_HLEN + 1;
    localparam int OFS_OPER  = OFS_PLEN + 1;
    localparam int OFS_SHA   = OFS_OPER + 2;
    localparam int OFS_SPA   = OFS_SHA + MAC_BYTES;
    localparam int OFS_THA   = OFS_SPA + IP_BYTES;
    localparam int OFS_TPA   = OFS_THA + MAC_BYTES;
    localparam int BODY_LEN  = OFS_TPA + IP_BYTES;
    localparam int BODY_W    = BODY_LEN * BYTE_W;
    localparam int CNT_W     = $clog2(BODY_LEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_HOLD = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] htype;
        logic [WORD_W-1:0] ptype;
        logic [BYTE_W-1:0] hlen;
        logic [BYTE_W-1:0] plen;
        logic [WORD_W-1:0] oper;
        logic [MAC_W-1:0]  sha;
        logic [IP_W-1:0]   spa;
        logic [MAC_W-1:0]  tha;
        logic [IP_W-1:0]   tpa;
    } arp_fields_t;

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [MAC_W-1:0]   dst;
        logic [MAC_W-1:0]   src;
        logic [ETYPE_W-1:0] etype;
        logic               e_short;
        logic               e_hdr;
        logic               e_bad;
    } rx_ctl_t;

endpackage

// File: rtl/arp_body_store.sv
module arp_body_store
    import arp_unpack_pkg::*;
#(
    parameter int LANES = BODY_LEN,
    parameter int IDX_W = CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_byte,
    output wire  [LANES*BYTE_W-1:0] body
);

    // one byte register per body position; lane 0 sits in the top bits
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                lane_d = wr_byte;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign body[(LANES-1-g)*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/arp_body_decode.sv
module arp_body_decode
    import arp_unpack_pkg::*;
#(
    parameter logic [WORD_W-1:0] EXP_HTYPE = 16'h0001,
    parameter logic [WORD_W-1:0] EXP_PTYPE = 16'h0800,
    parameter logic [BYTE_W-1:0] EXP_HLEN  = 8'(MAC_BYTES),
    parameter logic [BYTE_W-1:0] EXP_PLEN  = 8'(IP_BYTES)
) (
    input  logic [BODY_W-1:0] body,
    output arp_fields_t       fields,
    output logic              hdr_ok
);

    // top bit of the field that starts at byte offset o
    localparam int TOP_HTYPE = (BODY_LEN - OFS_HTYPE) * BYTE_W - 1;
    localparam int TOP_PTYPE = (BODY_LEN - OFS_PTYPE) * BYTE_W - 1;
    localparam int TOP_HLEN  = (BODY_LEN - OFS_HLEN)  * BYTE_W - 1;
    localparam int TOP_PLEN  = (BODY_LEN - OFS_PLEN)  * BYTE_W - 1;
    localparam int TOP_OPER  = (BODY_LEN - OFS_OPER)  * BYTE_W - 1;
    localparam int TOP_SHA   = (BODY_LEN - OFS_SHA)   * BYTE_W - 1;
    localparam int TOP_SPA   = (BODY_LEN - OFS_SPA)   * BYTE_W - 1;
    localparam int TOP_THA   = (BODY_LEN - OFS_THA)   * BYTE_W - 1;
    localparam int TOP_TPA   = (BODY_LEN - OFS_TPA)   * BYTE_W - 1;

    always_comb begin
        fields.htype = body[TOP_HTYPE -: WORD_W];
        fields.ptype = body[TOP_PTYPE -: WORD_W];
        fields.hlen  = body[TOP_HLEN  -: BYTE_W];
        fields.plen  = body[TOP_PLEN  -: BYTE_W];
        fields.oper  = body[TOP_OPER  -: WORD_W];
        fields.sha   = body[TOP_SHA   -: MAC_W];
        fields.spa   = body[TOP_SPA   -: IP_W];
        fields.tha   = body[TOP_THA   -: MAC_W];
        fields.tpa   = body[TOP_TPA   -: IP_W];
    end

    assign hdr_ok = (fields.htype == EXP_HTYPE) && (fields.ptype == EXP_PTYPE)
                 && (fields.hlen == EXP_HLEN) && (fields.plen == EXP_PLEN);

endmodule

// File: rtl/arp_frame_unpacker.sv
module arp_frame_unpacker
    import arp_unpack_pkg::*;
#(
    parameter logic [WORD_W-1:0] EXP_HTYPE = 16'h0001,
    parameter logic [WORD_W-1:0] EXP_PTYPE = 16'h0800,
    parameter logic [BYTE_W-1:0] EXP_HLEN  = 8'(MAC_BYTES),
    parameter logic [BYTE_W-1:0] EXP_PLEN  = 8'(IP_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [MAC_W-1:0]   hdr_dst_mac,
    input  logic [MAC_W-1:0]   hdr_src_mac,
    input  logic [ETYPE_W-1:0] hdr_ethtype,
    input  logic [BYTE_W-1:0]  pl_tdata,
    input  logic               pl_tvalid,
    output logic               pl_tready,
    input  logic               pl_tlast,
    input  logic               pl_tuser,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [MAC_W-1:0]   out_dst_mac,
    output logic [MAC_W-1:0]   out_src_mac,
    output logic [ETYPE_W-1:0] out_ethtype,
    output logic [WORD_W-1:0]  out_htype,
    output logic [WORD_W-1:0]  out_ptype,
    output logic [BYTE_W-1:0]  out_hlen,
    output logic [BYTE_W-1:0]  out_plen,
    output logic [WORD_W-1:0]  out_oper,
    output logic [MAC_W-1:0]   out_sha,
    output logic [IP_W-1:0]    out_spa,
    output logic [MAC_W-1:0]   out_tha,
    output logic [IP_W-1:0]    out_tpa,
    output logic               busy,
    output logic               err_short,
    output logic               err_hdr,
    output logic               err_bad
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BODY_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BODY_LEN - 1);

    rx_ctl_t           ctl_d, ctl_q;
    logic              beat;
    logic              wr_en;
    logic              hdr_ok;
    logic [BODY_W-1:0] body;
    arp_fields_t       fields;

    arp_body_store #(
        .LANES (BODY_LEN),
        .IDX_W (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ctl_q.cnt),
        .wr_byte (pl_tdata),
        .body    (body)
    );

    arp_body_decode #(
        .EXP_HTYPE (EXP_HTYPE),
        .EXP_PTYPE (EXP_PTYPE),
        .EXP_HLEN  (EXP_HLEN),
        .EXP_PLEN  (EXP_PLEN)
    ) u_decode (
        .body   (body),
        .fields (fields),
        .hdr_ok (hdr_ok)
    );

    assign hdr_ready = (ctl_q.st == ST_IDLE);
    assign pl_tready = (ctl_q.st == ST_RECV);
    assign beat      = pl_tvalid && pl_tready;
    assign wr_en     = beat && (ctl_q.cnt < CNT_FULL);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.e_short = 1'b0;
        ctl_d.e_hdr   = 1'b0;
        ctl_d.e_bad   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (hdr_valid) begin
                    ctl_d.st    = ST_RECV;
                    ctl_d.cnt   = '0;
                    ctl_d.dst   = hdr_dst_mac;
                    ctl_d.src   = hdr_src_mac;
                    ctl_d.etype = hdr_ethtype;
                end
            end
            ST_RECV: begin
                if (beat) begin
                    // counter saturates so trailing bytes land nowhere
                    if (ctl_q.cnt < CNT_FULL) begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                    if (pl_tlast) begin
                        if (pl_tuser) begin
                            ctl_d.e_bad = 1'b1;
                            ctl_d.st    = ST_IDLE;
                        end else if (ctl_q.cnt < CNT_LAST) begin
                            ctl_d.e_short = 1'b1;
                            ctl_d.st      = ST_IDLE;
                        end else if (!hdr_ok) begin
                            // constant bytes were all stored before the last index
                            ctl_d.e_hdr = 1'b1;
                            ctl_d.st    = ST_IDLE;
                        end else begin
                            ctl_d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_valid   = (ctl_q.st == ST_HOLD);
    assign busy        = (ctl_q.st != ST_IDLE);
    assign err_short   = ctl_q.e_short;
    assign err_hdr     = ctl_q.e_hdr;
    assign err_bad     = ctl_q.e_bad;
    assign out_dst_mac = ctl_q.dst;
    assign out_src_mac = ctl_q.src;
    assign out_ethtype = ctl_q.etype;
    assign out_htype   = fields.htype;
    assign out_ptype   = fields.ptype;
    assign out_hlen    = fields.hlen;
    assign out_plen    = fields.plen;
    assign out_oper    = fields.oper;
    assign out_sha     = fields.sha;
    assign out_spa     = fields.spa;
    assign out_tha     = fields.tha;
    assign out_tpa     = fields.tpa;

endmodule

// File: rtl/arp_frame_unpacker_chk.sv
module arp_frame_unpacker_chk
    import arp_unpack_pkg::*;
#(
    parameter logic [WORD_W-1:0] EXP_HTYPE = 16'h0001,
    parameter logic [WORD_W-1:0] EXP_PTYPE = 16'h0800,
    parameter logic [BYTE_W-1:0] EXP_HLEN  = 8'(MAC_BYTES),
    parameter logic [BYTE_W-1:0] EXP_PLEN  = 8'(IP_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic              hdr_ready,
    input logic              pl_tvalid,
    input logic              pl_tready,
    input logic              pl_tlast,
    input logic              pl_tuser,
    input logic              out_valid,
    input logic              out_ready,
    input logic [MAC_W-1:0]  out_dst_mac,
    input logic [WORD_W-1:0] out_htype,
    input logic [WORD_W-1:0] out_ptype,
    input logic [BYTE_W-1:0] out_hlen,
    input logic [BYTE_W-1:0] out_plen,
    input logic [MAC_W-1:0]  out_sha,
    input logic [IP_W-1:0]   out_tpa,
    input logic              busy,
    input logic              err_short,
    input logic              err_hdr,
    input logic              err_bad
);

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ready && pl_tready));

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sha)
                                       && $stable(out_tpa) && $stable(out_dst_mac)));

    p_emit_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(pl_tvalid && pl_tready && pl_tlast && !pl_tuser));

    p_short_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> !err_short);

    p_err_no_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_short || err_hdr || err_bad) |-> !out_valid);

    p_consts_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_htype == EXP_HTYPE && out_ptype == EXP_PTYPE
                       && out_hlen == EXP_HLEN && out_plen == EXP_PLEN));

    p_bad_from_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad |-> $past(pl_tvalid && pl_tready && pl_tlast && pl_tuser));

    p_pending_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!pl_tready && !hdr_ready));

    p_busy_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> busy);

    p_err_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_short, err_hdr, err_bad}));

endmodule

bind arp_frame_unpacker arp_frame_unpacker_chk #(
    .EXP_HTYPE (EXP_HTYPE),
    .EXP_PTYPE (EXP_PTYPE),
    .EXP_HLEN  (EXP_HLEN),
    .EXP_PLEN  (EXP_PLEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_ready   (hdr_ready),
    .pl_tvalid   (pl_tvalid),
    .pl_tready   (pl_tready),
    .pl_tlast    (pl_tlast),
    .pl_tuser    (pl_tuser),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_dst_mac (out_dst_mac),
    .out_htype   (out_htype),
    .out_ptype   (out_ptype),
    .out_hlen    (out_hlen),
    .out_plen    (out_plen),
    .out_sha     (out_sha),
    .out_tpa     (out_tpa),
    .busy        (busy),
    .err_short   (err_short),
    .err_hdr     (err_hdr),
    .err_bad     (err_bad)
);

// File: tb/arp_frame_unpacker_test.sv
module arp_frame_unpacker_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] len;
        logic       tuser;
        logic       gap;
        logic [2:0] badf;   // 0 none, 1 htype, 2 ptype, 3 hlen, 4 plen
        logic [1:0] expo;   // 0 emit, 1 short, 2 header, 3 bad
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{8'd28, 1'b0, 1'b0, 3'd0, 2'd0},
        '{8'd28, 1'b0, 1'b1, 3'd0, 2'd0},
        '{8'd32, 1'b0, 1'b0, 3'd0, 2'd0},
        '{8'd60, 1'b0, 1'b1, 3'd0, 2'd0},
        '{8'd27, 1'b0, 1'b0, 3'd0, 2'd1},
        '{8'd1,  1'b0, 1'b0, 3'd0, 2'd1},
        '{8'd28, 1'b0, 1'b0, 3'd1, 2'd2},
        '{8'd28, 1'b0, 1'b1, 3'd2, 2'd2},
        '{8'd28, 1'b0, 1'b0, 3'd3, 2'd2},
        '{8'd30, 1'b0, 1'b0, 3'd4, 2'd2},
        '{8'd28, 1'b1, 1'b0, 3'd0, 2'd3},
        '{8'd5,  1'b1, 1'b0, 3'd0, 2'd3},
        '{8'd28, 1'b1, 1'b0, 3'd1, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [47:0] hdr_dst_mac = '0;
    logic [47:0] hdr_src_mac = '0;
    logic [15:0] hdr_ethtype = '0;
    logic [7:0]  pl_tdata = '0;
    logic        pl_tvalid = 1'b0;
    logic        pl_tready;
    logic        pl_tlast = 1'b0;
    logic        pl_tuser = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [47:0] out_dst_mac, out_src_mac;
    logic [15:0] out_ethtype, out_htype, out_ptype, out_oper;
    logic [7:0]  out_hlen, out_plen;
    logic [47:0] out_sha, out_tha;
    logic [31:0] out_spa, out_tpa;
    logic        busy, err_short, err_hdr, err_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    arp_frame_unpacker uut (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_dst_mac(hdr_dst_mac), .hdr_src_mac(hdr_src_mac), .hdr_ethtype(hdr_ethtype),
        .pl_tdata(pl_tdata), .pl_tvalid(pl_tvalid), .pl_tready(pl_tready),
        .pl_tlast(pl_tlast), .pl_tuser(pl_tuser),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dst_mac(out_dst_mac), .out_src_mac(out_src_mac), .out_ethtype(out_ethtype),
        .out_htype(out_htype), .out_ptype(out_ptype), .out_hlen(out_hlen), .out_plen(out_plen),
        .out_oper(out_oper), .out_sha(out_sha), .out_spa(out_spa), .out_tha(out_tha),
        .out_tpa(out_tpa), .busy(busy),
        .err_short(err_short), .err_hdr(err_hdr), .err_bad(err_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [223:0] act, input logic [223:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [223:0] exp_body(input int i, input logic [2:0] badf);
        logic [15:0] ht = 16'h0001;
        logic [15:0] pt = 16'h0800;
        logic [7:0]  hl = 8'd6;
        logic [7:0]  pl = 8'd4;
        case (badf)
            3'd1: ht = 16'h0006;
            3'd2: pt = 16'h86DD;
            3'd3: hl = 8'd8;
            3'd4: pl = 8'd16;
            default: ;
        endcase
        return {ht, pt, hl, pl, 16'h0001 + i[15:0],
                8'h02, i[7:0], 32'hA1B2C3D4,
                32'h0A000001 + i[31:0],
                16'hDEAD, i[7:0], 24'h5A5A5A,
                32'hC0A80100 + i[31:0]};
    endfunction

    function automatic logic [223:0] out_flat();
        return {out_htype, out_ptype, out_hlen, out_plen, out_oper,
                out_sha, out_spa, out_tha, out_tpa};
    endfunction

    task automatic run_frame(input int i, input vec_t v, input bit noisy);
        logic [223:0] body;
        logic [47:0]  src;
        logic [3:0]   exp_flags;
        string        req;
        body = exp_body(i, v.badf);
        src  = {40'h0002030405, i[7:0]};
        @(negedge clk);
        hdr_valid   = 1'b1;
        hdr_dst_mac = 48'hFFFF_FFFF_FFFF;
        hdr_src_mac = src;
        hdr_ethtype = 16'h0806;
        while (!hdr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = noisy;
        if (noisy) begin
            hdr_dst_mac = 48'h1111_1111_1111;
            hdr_src_mac = '0;
            hdr_ethtype = 16'h0800;
        end
        check({busy, pl_tready, hdr_ready} == 3'b110, "R9", "busy and readies after header",
              {busy, pl_tready, hdr_ready}, 3'b110);
        for (int k = 0; k < int'(v.len); k++) begin
            if (v.gap && (k % 3 == 2)) begin
                pl_tvalid = 1'b0;
                @(negedge clk);
            end
            pl_tvalid = 1'b1;
            pl_tdata  = (k < 28) ? body[(27-k)*8 +: 8] : 8'hEE;
            pl_tlast  = (k == int'(v.len) - 1);
            pl_tuser  = v.tuser && (k == int'(v.len) - 1);
            if (k == int'(v.len) - 1) begin
                check(!out_valid, "R3", "no record before last beat", out_valid, 0);
            end
            while (!pl_tready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        pl_tvalid = 1'b0;
        pl_tlast  = 1'b0;
        pl_tuser  = 1'b0;
        hdr_valid = 1'b0;
        case (v.expo)
            2'd0: begin exp_flags = 4'b1000; req = (v.len > 8'd28) ? "R4" : "R3"; end
            2'd1: begin exp_flags = 4'b0100; req = "R5"; end
            2'd2: begin exp_flags = 4'b0010; req = "R6"; end
            default: begin exp_flags = 4'b0001; req = "R7"; end
        endcase
        check({out_valid, err_short, err_hdr, err_bad} == exp_flags, req,
              $sformatf("outcome vec %0d", i), {out_valid, err_short, err_hdr, err_bad}, exp_flags);
        if (v.expo == 2'd0) begin
            check(out_flat() == body, "R2", "parsed fields", out_flat(), body);
            check({out_dst_mac, out_src_mac, out_ethtype} == {48'hFFFF_FFFF_FFFF, src, 16'h0806},
                  "R1", "forwarded header", {out_dst_mac, out_src_mac, out_ethtype},
                  {48'hFFFF_FFFF_FFFF, src, 16'h0806});
            @(negedge clk);
            @(negedge clk);
            check({out_valid, pl_tready, hdr_ready, busy} == 4'b1001, "R8",
                  "held record blocks inputs", {out_valid, pl_tready, hdr_ready, busy}, 4'b1001);
            check(out_flat() == body, "R3", "fields stable while held", out_flat(), body);
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
            check({out_valid, busy, hdr_ready} == 3'b001, "R9", "released after handshake",
                  {out_valid, busy, hdr_ready}, 3'b001);
        end else begin
            check($countones({err_short, err_hdr, err_bad}) <= 1 && !busy, "R11",
                  "single error flag, busy low", {busy, err_short, err_hdr, err_bad}, 0);
            @(negedge clk);
            check({err_short, err_hdr, err_bad} == 3'b000, "R5", "error is one-cycle pulse",
                  {err_short, err_hdr, err_bad}, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // reset state, R10
        repeat (3) @(negedge clk);
        check({out_valid, busy, pl_tready, hdr_ready, err_short, err_hdr, err_bad} == 7'b0001000,
              "R10", "reset state", {out_valid, busy, pl_tready, hdr_ready, err_short, err_hdr, err_bad},
              7'b0001000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_frame(i, VECS[i], 1'b0);
        end

        // header offered during payload must not replace captured words (R1)
        run_frame(40, VECS[0], 1'b1);

        // asynchronous reset in the middle of a frame (R10)
        @(negedge clk);
        hdr_valid   = 1'b1;
        hdr_dst_mac = 48'h0A0B0C0D0E0F;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        pl_tvalid = 1'b1;
        pl_tdata  = 8'h00;
        repeat (10) @(negedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check({busy, pl_tready, out_valid, hdr_ready} == 4'b0001, "R10", "mid-frame reset",
              {busy, pl_tready, out_valid, hdr_ready}, 4'b0001);
        pl_tvalid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(21, VECS[0], 1'b0);

        finish_run();
    end

endmodule